// File: doc/BRIEF.md
# Single-Slope Fast PWM Timer

This block is a 16-bit up-counter that generates edge-aligned PWM waveforms on two compare channels. The counter advances on each clock where the `tick` enable is high, runs from zero up to a period limit (TOP), and returns to zero on the following tick. A 4-bit mode code chooses TOP. It can be one of three fixed limits (8, 9 or 10 bits), the capture register, or the channel A compare register. Each channel has a 2-bit output-mode field that selects disconnected, non-inverting or inverting operation.

Software writes the compare and capture values into shadow buffers. The buffered values move into the working registers together on the tick taken at TOP, so period and duty change only on a period boundary. Sticky flags report overflow, per-channel compare matches and a capture-register event. Writing 1 to a flag bit clears it.

Each channel runs a three-state machine. `CH_OFF` holds the output low. `CH_LEAD` is the part of the period from BOTTOM up to the match, and `CH_TRAIL` is the part after the match. The transitions are:
- OFF→TRAIL when the channel is enabled.
- LEAD/TRAIL→OFF when the channel is disabled.
- any active state→LEAD on the wrap tick.
- LEAD/TRAIL→TRAIL on a match tick that is not a wrap.

The output is decoded from the state. It is high in LEAD and low in TRAIL for non-inverting operation, and the reverse for inverting operation.

Top module: `fpwm_timer`

## Requirements
- R1: With `tick` high, the count rises by one per clock. The tick taken while the count equals TOP loads zero. With `tick` low, the count holds.
- R2: TOP is set by `mode`:
  - 5 gives 0x00FF.
  - 6 gives 0x01FF.
  - 7 gives 0x03FF.
  - 14 gives the working capture value.
  - 15 gives the working channel-0 compare value.
  - Any other code gives 0xFFFF.
- R3: A register-defined TOP below 3 is used as 3, so TOP is never smaller than 3.
- R4: In output mode 2 (non-inverting), the channel output is high from BOTTOM through the count equal to the compare value, which is cmp+1 ticks of a TOP+1 period. It is low for the rest of the period. With cmp ≥ TOP, the output stays high for the whole period.
- R5: Output mode 3 (inverting) gives the complement of R4 over the period.
- R6: Output modes 0 and 1 drive the channel output low from the next clock onward.
- R7: Flag bit 0 (overflow) is set by the tick taken while the count equals TOP.
- R8: In mode 15, flag bit 1 is set on the same tick as the overflow flag. In mode 14, flag bit 3 (capture) is set on that same tick.
- R9: Flag bit 1+i is set by a tick taken while the count equals channel i's working compare value. A compare value above TOP never sets it.
- R10: A write with `wr_sel` 0 or 1 goes to that channel's compare buffer, and `wr_sel` 2 goes to the capture buffer. Buffers are copied to the working registers only on the tick taken at TOP.
- R11: Flags are sticky and are cleared by a 1 in the matching `flag_clr` bit. A set event in the same clock wins over the clear.
- R12: During reset, the count, the outputs, the flags and all registers are zero, and the channels are in `CH_OFF`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one count per high clock |
| mode | input | 4 | TOP selection code |
| out_mode | input | 4 | Output modes, channel 0 in [1:0], channel 1 in [3:2] |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0/1 compare channel, 2 capture |
| wr_data | input | 16 | Write data |
| flag_clr | input | 4 | Write-1-to-clear per flag bit |
| cnt | output | 16 | Current count |
| pwm_out | output | 2 | Channel waveforms |
| flags | output | 4 | bit0 overflow, bit1/bit2 channel match, bit3 capture |

## Verification
The hardest situations to reach are those where a set event and a clear request, or a buffer write and the TOP load, fall on the same clock edge. From the ports, the only reference for hitting that edge is the visible count.

The bench first synchronises to a wrap. It then drives `flag_clr` exactly in the cycle where the count equals TOP. In a separate test, it rewrites the compare and capture buffers in the middle of a period. It then shows that the running period still ends at the old TOP and that the following period uses the new values.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_LEAD  = 2'd1,
        CH_TRAIL = 2'd2
    } ch_state_e;

    localparam logic [3:0] MODE_TOP8     = 4'd5;
    localparam logic [3:0] MODE_TOP9     = 4'd6;
    localparam logic [3:0] MODE_TOP10    = 4'd7;
    localparam logic [3:0] MODE_TOP_CAP  = 4'd14;
    localparam logic [3:0] MODE_TOP_CMPA = 4'd15;

endpackage

// File: rtl/fpwm_regs.sv
module fpwm_regs
    import fpwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CH  = 2,
    parameter int SEL_W   = 2,
    parameter int MIN_TOP = 3,
    parameter int TOP_8   = 255,
    parameter int TOP_9   = 511,
    parameter int TOP_10  = 1023
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [CNT_W-1:0]               wr_data,
    input  logic                           load,
    input  logic [3:0]                     mode,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_act,
    output logic [CNT_W-1:0]               top_val,
    output logic                           top_from_cmpa,
    output logic                           top_from_cap
);
    localparam int NREG    = NUM_CH + 1;
    localparam int CAP_IDX = NUM_CH;

    logic [CNT_W-1:0] buf_q [NREG];
    logic [CNT_W-1:0] act_q [NREG];

    function automatic logic [CNT_W-1:0] floor_top(input logic [CNT_W-1:0] v);
        return (v < CNT_W'(MIN_TOP)) ? CNT_W'(MIN_TOP) : v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                buf_q[i] <= '0;
                act_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_en && (wr_sel == SEL_W'(i)))
                    buf_q[i] <= wr_data;
                if (load)
                    act_q[i] <= buf_q[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            cmp_act[i] = act_q[i];
    end

    always_comb begin
        top_from_cmpa = 1'b0;
        top_from_cap  = 1'b0;
        case (mode)
            MODE_TOP8:  top_val = CNT_W'(TOP_8);
            MODE_TOP9:  top_val = CNT_W'(TOP_9);
            MODE_TOP10: top_val = CNT_W'(TOP_10);
            MODE_TOP_CAP: begin
                top_val      = floor_top(act_q[CAP_IDX]);
                top_from_cap = 1'b1;
            end
            MODE_TOP_CMPA: begin
                top_val       = floor_top(act_q[0]);
                top_from_cmpa = 1'b1;
            end
            default:    top_val = '1;
        endcase
    end

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = tick && (cnt == top_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end

endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wrap,
    input  logic [1:0]       out_mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             pwm,
    output logic             match
);
    ch_state_e state_q, state_d;
    logic      enabled;
    logic      invert;

    assign enabled = out_mode[1];
    assign invert  = out_mode[0];
    assign match   = tick && (cnt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (enabled)
                    state_d = CH_TRAIL;
            end
            CH_LEAD, CH_TRAIL: begin
                if (!enabled)
                    state_d = CH_OFF;
                else if (wrap)
                    state_d = CH_LEAD;
                else if (match)
                    state_d = CH_TRAIL;
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CH_LEAD:  pwm = ~invert;
            CH_TRAIL: pwm = invert;
            default:  pwm = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpwm_flags.sv
module fpwm_flags #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_ev,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr) | set_ev;
    end

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
    import fpwm_pkg::*;
#(
    parameter  int CNT_W   = 16,
    parameter  int NUM_CH  = 2,
    parameter  int MIN_TOP = 3,
    parameter  int TOP_8   = 255,
    parameter  int TOP_9   = 511,
    parameter  int TOP_10  = 1023,
    localparam int SEL_W   = $clog2(NUM_CH + 1),
    localparam int NFLAG   = NUM_CH + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [3:0]            mode,
    input  logic [2*NUM_CH-1:0]   out_mode,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [NFLAG-1:0]      flag_clr,
    output logic [CNT_W-1:0]      cnt,
    output logic [NUM_CH-1:0]     pwm_out,
    output logic [NFLAG-1:0]      flags
);
    logic [CNT_W-1:0]             top_val;
    logic                         wrap;
    logic                         top_from_cmpa;
    logic                         top_from_cap;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
    logic [NUM_CH-1:0]            match_ev;
    logic [NFLAG-1:0]             flag_set;

    fpwm_regs #(
        .CNT_W   (CNT_W),
        .NUM_CH  (NUM_CH),
        .SEL_W   (SEL_W),
        .MIN_TOP (MIN_TOP),
        .TOP_8   (TOP_8),
        .TOP_9   (TOP_9),
        .TOP_10  (TOP_10)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .load          (wrap),
        .mode          (mode),
        .cmp_act       (cmp_act),
        .top_val       (top_val),
        .top_from_cmpa (top_from_cmpa),
        .top_from_cap  (top_from_cap)
    );

    fpwm_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .top_val (top_val),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        fpwm_channel #(
            .CNT_W (CNT_W)
        ) u_channel (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wrap     (wrap),
            .out_mode (out_mode[2*i +: 2]),
            .cnt      (cnt),
            .cmp      (cmp_act[i]),
            .pwm      (pwm_out[i]),
            .match    (match_ev[i])
        );
    end

    always_comb begin
        flag_set[0] = wrap;
        for (int i = 0; i < NUM_CH; i++)
            flag_set[1+i] = match_ev[i];
        flag_set[1]       = match_ev[0] | (top_from_cmpa & wrap);
        flag_set[NFLAG-1] = top_from_cap & wrap;
    end

    fpwm_flags #(
        .NF (NFLAG)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (flag_set),
        .clr    (flag_clr),
        .flags  (flags)
    );

endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk
    import fpwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CH  = 2,
    parameter int MIN_TOP = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic [3:0]          mode,
    input logic [2*NUM_CH-1:0] out_mode,
    input logic [NUM_CH+1:0]   flag_clr,
    input logic [NUM_CH+1:0]   flags,
    input logic [CNT_W-1:0]    cnt,
    input logic [CNT_W-1:0]    top_val,
    input logic                wrap,
    input logic [NUM_CH-1:0]   pwm_out
);
    localparam int NFLAG = NUM_CH + 2;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != top_val) |=> (cnt == $past(cnt) + CNT_W'(1))); // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == top_val) |=> (cnt == '0)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R1
    AST_TOP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        top_val >= CNT_W'(MIN_TOP)); // R3
    AST_OVF_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == top_val) |=> flags[0]); // R7
    AST_CAP_FLAG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == top_val && mode == MODE_TOP_CAP) |=> flags[NFLAG-1]); // R8

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk_ch
        AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !out_mode[2*c+1] |=> !pwm_out[c]); // R6
        AST_BOTTOM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wrap) && $past(out_mode[2*c+1], 2) && $past(out_mode[2*c+1]) && out_mode[2*c+1])
            |-> (pwm_out[c] == !out_mode[2*c])); // R4, R5
    end

    for (genvar k = 0; k < NFLAG; k++) begin : g_chk_flag
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[k] && !flag_clr[k]) |=> flags[k]); // R11
    end

endmodule

bind fpwm_timer fpwm_timer_chk #(
    .CNT_W   (CNT_W),
    .NUM_CH  (NUM_CH),
    .MIN_TOP (MIN_TOP)
) u_fpwm_timer_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode),
    .out_mode (out_mode),
    .flag_clr (flag_clr),
    .flags    (flags),
    .cnt      (cnt),
    .top_val  (top_val),
    .wrap     (wrap),
    .pwm_out  (pwm_out)
);

// File: tb/fpwm_timer_bench.sv
`timescale 1ns/1ps
module fpwm_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [3:0]  mode;
    logic [3:0]  out_mode;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [3:0]  flag_clr;
    logic [15:0] cnt;
    logic [1:0]  pwm_out;
    logic [3:0]  flags;

    always #5 clk = ~clk;

    fpwm_timer u_fpwm_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode),
        .out_mode (out_mode),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .flag_clr (flag_clr),
        .cnt      (cnt),
        .pwm_out  (pwm_out),
        .flags    (flags)
    );

    typedef struct packed {
        logic [3:0]  md;
        logic [3:0]  om;
        logic [15:0] ca;
        logic [15:0] cb;
        logic [15:0] cap;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd5,  4'b1010, 16'h0040, 16'h0080, 16'h0000},
        '{4'd6,  4'b1011, 16'h0100, 16'h01FF, 16'h0000},
        '{4'd7,  4'b1110, 16'h0404, 16'h0000, 16'h0000},
        '{4'd14, 4'b1010, 16'h0002, 16'h000A, 16'h0014},
        '{4'd14, 4'b1010, 16'h0001, 16'h0005, 16'h0003},
        '{4'd15, 4'b1010, 16'h0009, 16'h0004, 16'h0000},
        '{4'd15, 4'b1100, 16'h000C, 16'h0003, 16'h0000},
        '{4'd14, 4'b0110, 16'h0001, 16'h0001, 16'h0002}
    };

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int exp_top(input logic [3:0] m, input int a, input int cap);
        case (m)
            4'd5:    return 255;
            4'd6:    return 511;
            4'd7:    return 1023;
            4'd14:   return (cap < 3) ? 3 : cap;
            4'd15:   return (a < 3) ? 3 : a;
            default: return 65535;
        endcase
    endfunction

    function automatic int exp_high(input logic [1:0] om, input int cmp, input int top);
        int base;
        if (om < 2) return 0;
        base = (cmp >= top) ? top + 1 : cmp + 1;
        return (om == 2'd3) ? (top + 1 - base) : base;
    endfunction

    task automatic do_reset(input logic [3:0] m, input logic [3:0] om);
        rst_n    = 1'b0;
        tick     = 1'b0;
        wr_en    = 1'b0;
        flag_clr = '0;
        mode     = m;
        out_mode = om;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        for (int g = 0; g < 70000 && cnt != 16'(v); g++) @(negedge clk);
    endtask

    task automatic wait_wrap();
        for (int g = 0; g < 70000 && cnt == 16'd0; g++) @(negedge clk);
        for (int g = 0; g < 70000 && cnt != 16'd0; g++) @(negedge clk);
    endtask

    task automatic measure(output int per, output int ha, output int hb);
        per = 0; ha = 0; hb = 0;
        do begin
            per++;
            ha += int'(pwm_out[0]);
            hb += int'(pwm_out[1]);
            @(negedge clk);
        end while (cnt != 16'd0 && per < 70000);
    endtask

    initial begin
        int per, ha, hb, t, mx, c0;
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        flag_clr = '0; mode = 4'd5; out_mode = 4'b1010;
        repeat (2) @(negedge clk);
        tick = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R12 reset count", int'(cnt), 0);
        check_eq("R12 reset outputs", int'(pwm_out), 0);
        check_eq("R12 reset flags", int'(flags), 0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            do_reset(VECS[i].md, VECS[i].om);
            wr(2'd0, VECS[i].ca);
            wr(2'd1, VECS[i].cb);
            wr(2'd2, VECS[i].cap);
            tick = 1'b1;
            wait_wrap();
            measure(per, ha, hb);
            t = exp_top(VECS[i].md, int'(VECS[i].ca), int'(VECS[i].cap));
            check_eq($sformatf("R2 R3 period vector %0d", i), per, t + 1);
            check_eq($sformatf("R4 R5 R6 channel A high ticks vector %0d", i), ha,
                     exp_high(VECS[i].om[1:0], int'(VECS[i].ca), t));
            check_eq($sformatf("R4 R5 R6 channel B high ticks vector %0d", i), hb,
                     exp_high(VECS[i].om[3:2], int'(VECS[i].cb), t));
        end

        // R1 counting, holding and wrapping
        do_reset(4'd5, 4'b0000);
        tick = 1'b1;
        repeat (10) @(negedge clk);
        check_eq("R1 count after ten ticks", int'(cnt), 10);
        tick = 1'b0;
        c0 = int'(cnt);
        repeat (5) @(negedge clk);
        check_eq("R1 hold with tick low", int'(cnt), c0);
        tick = 1'b1;
        wait_cnt(255);
        @(negedge clk);
        check_eq("R1 wrap after fixed TOP", int'(cnt), 0);

        // R2 other mode codes run to full width
        do_reset(4'd0, 4'b0000);
        tick = 1'b1;
        repeat (1100) @(negedge clk);
        check_eq("R2 unlisted mode counts past 10-bit limit", int'(cnt), 1100);

        // R7 R8 R9 R11 flags
        do_reset(4'd14, 4'b0000);
        wr(2'd0, 16'd20);
        wr(2'd1, 16'd20);
        wr(2'd2, 16'd5);
        tick = 1'b1;
        wait_wrap();
        check_eq("R7 overflow flag at first TOP", int'(flags[0]), 1);
        check_eq("R8 capture flag with overflow", int'(flags[3]), 1);
        wait_cnt(2);
        flag_clr = 4'hF;
        @(negedge clk);
        flag_clr = 4'h0;
        check_eq("R11 write-1 clear of all flags", int'(flags), 0);
        wait_cnt(5);
        flag_clr = 4'h1;
        @(negedge clk);
        flag_clr = 4'h0;
        check_eq("R11 set wins over clear at TOP", int'(flags), 9);
        check_eq("R9 compare above TOP never matches", int'(flags[2:1]), 0);
        wr(2'd1, 16'd2);
        wait_wrap();
        flag_clr = 4'hF;
        @(negedge clk);
        flag_clr = 4'h0;
        check_eq("R9 no match before compare count", int'(flags[2]), 0);
        wait_cnt(3);
        check_eq("R9 match flag after compare count", int'(flags[2]), 1);

        // R10 buffered update takes effect at TOP
        do_reset(4'd14, 4'b1000);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd20);
        tick = 1'b1;
        wait_wrap();
        wait_cnt(3);
        wr(2'd1, 16'd10);
        wr(2'd2, 16'd30);
        mx = 0;
        for (int g = 0; g < 70000 && cnt != 16'd0; g++) begin
            if (int'(cnt) > mx) mx = int'(cnt);
            @(negedge clk);
        end
        check_eq("R10 running period keeps old TOP", mx, 20);
        measure(per, ha, hb);
        check_eq("R10 next period uses new TOP", per, 31);
        check_eq("R10 next period uses new compare", hb, 11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule